// File: doc/BRIEF.md
# SRAM-to-Host Interlocked Byte Transfer

This block moves a captured frame out of an asynchronous SRAM to a slower host controller, one byte at a time. A start pulse gives it a byte count. From then on it walks the SRAM upward from a fixed base address. For every byte it runs a four-phase interlock with the host: the host raises its ready-to-receive line, the block reads the next location and drives the byte, then it raises data-ready. The host takes the byte and drops ready-to-receive. Only after that does the block drop data-ready and move to the next address.

The host runs on an unrelated clock, so its ready-to-receive line passes through a two-flop synchroniser before the control logic uses it. Once the last byte's interlock has closed, a done flag rises. It stays high until the next start.

Top module: `sram_host_xfer`

## Requirements
- R1: After reset, data-ready, done and SRAM output enable are low, and the SRAM address equals the base address.
- R2: A start pulse is accepted only when the block is idle or done. It latches the byte count and clears done. A start pulse while a transfer is running has no effect on addresses, data or the point at which done rises.
- R3: Data-ready rises exactly 3 + RD_WAIT clock edges after ready-to-receive rises. These are two synchroniser edges, one decision edge and RD_WAIT read-settle edges.
- R4: While data-ready is high, the byte bus equals the SRAM content at the current address and does not change.
- R5: Data-ready stays high for as long as ready-to-receive stays high. It falls exactly 3 clock edges after ready-to-receive falls.
- R6: The byte delivered in handshake number i (counting from 0) comes from address base + i.
- R7: Done rises on the same edge as data-ready falls for the last byte. It stays high until the next accepted start. A start with a count of 0 raises done one edge later without any handshake.
- R8: The SRAM output enable is high only while a read is settling. It is low while idle, while waiting for the host, and while done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame transfer (one-cycle pulse) |
| xfer_len_i | input | CNT_W | Number of bytes to send, sampled at start |
| host_rtr_i | input | 1 | Host ready-to-receive, asynchronous |
| sram_rdata_i | input | DATA_W | SRAM read data |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_oe_o | output | 1 | SRAM output enable, high while reading |
| host_data_o | output | DATA_W | Byte bus to the host |
| data_rdy_o | output | 1 | Byte on the bus is valid |
| done_o | output | 1 | Whole transfer finished |

## Verification
Transfers of several lengths run with hosts that release ready-to-receive at once and hosts that hold it for several extra cycles. This separates a design that waits for the host's release from one that times out on its own. The SRAM model returns a value derived from the address, so a stuck, skipped or off-by-one address shows up in the byte data. Directed cases cover a zero-length start, a start pulse injected mid-transfer, and done held across idle cycles. They also measure the exact edge counts from the host's edges to data-ready, which exposes a missing or extra synchroniser stage.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_RDY,
    ST_DONE
  } xfer_state_e;
endpackage

// File: rtl/xfer_sync.sv
module xfer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
  parameter int ADDR_W = 21,
  parameter int CNT_W  = 19,
  parameter int BASE   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [CNT_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (inc_i) idx_q <= idx_q + CNT_W'(1);
  end

  assign idx_o  = idx_q;
  assign addr_o = ADDR_W'(BASE) + ADDR_W'(idx_q);

  // one location per completed handshake
  p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i |=> idx_q == $past(idx_q) + CNT_W'(1));
endmodule

// File: rtl/sram_host_xfer.sv
module sram_host_xfer
  import xfer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 21,
  parameter int MAX_BYTES = 340000,
  parameter int BASE_ADDR = 0,
  parameter int RD_WAIT   = 2,
  parameter int SYNC_STG  = 2,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  xfer_len_i,
  input  logic              host_rtr_i,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_oe_o,
  output logic [DATA_W-1:0] host_data_o,
  output logic              data_rdy_o,
  output logic              done_o
);
  localparam int WAIT_N = (RD_WAIT < 1) ? 1 : RD_WAIT;
  localparam int WT_W   = $clog2(WAIT_N + 1);

  xfer_state_e       state_q, state_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [WT_W-1:0]   wt_q, wt_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              rtr_s;
  logic              idx_clr, idx_inc, last_byte;
  logic [CNT_W-1:0]  idx;

  xfer_sync #(.STAGES(SYNC_STG)) u_rtr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (host_rtr_i),
    .q_o   (rtr_s)
  );

  xfer_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE(BASE_ADDR)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (idx_clr),
    .inc_i (idx_inc),
    .idx_o (idx),
    .addr_o(sram_addr_o)
  );

  assign last_byte = (idx + CNT_W'(1)) == len_q;

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    wt_d    = wt_q;
    data_d  = data_q;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          len_d   = xfer_len_i;
          idx_clr = 1'b1;
          state_d = (xfer_len_i == '0) ? ST_DONE : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rtr_s) begin
          wt_d    = '0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        wt_d = wt_q + WT_W'(1);
        if (wt_q == WT_W'(WAIT_N - 1)) begin
          data_d  = sram_rdata_i;  // read has settled
          state_d = ST_RDY;
        end
      end
      ST_RDY: begin
        if (!rtr_s) begin
          idx_inc = 1'b1;
          state_d = last_byte ? ST_DONE : ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      wt_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      wt_q    <= wt_d;
      data_q  <= data_d;
    end
  end

  assign host_data_o = data_q;
  assign data_rdy_o  = (state_q == ST_RDY);
  assign done_o      = (state_q == ST_DONE);
  assign sram_oe_o   = (state_q == ST_READ);

  p_rdy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rdy_o && rtr_s |=> data_rdy_o);

  p_bus_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rdy_o && rtr_s |=> $stable(host_data_o));

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !data_rdy_o && !sram_oe_o);

  p_done_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> idx == len_q);

  p_rdy_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_rdy_o, done_o, sram_oe_o}));
endmodule

// File: tb/sram_host_xfer_tb_top.sv
`timescale 1ns/1ps
module sram_host_xfer_tb_top;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 21;
  localparam int MAX_BYTES = 340000;
  localparam int BASE      = 'h1F0;
  localparam int RD_WAIT   = 2;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int UP_EDGES  = 3 + RD_WAIT;
  localparam int DN_EDGES  = 3;

  // {length, extra host hold cycles}
  localparam logic [15:0] VEC [4] = '{
    {8'd1, 8'd0}, {8'd3, 8'd2}, {8'd4, 8'd0}, {8'd2, 8'd5}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  len = '0;
  logic              rtr = 1'b0;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] addr;
  logic              oe, rdy, done;
  logic [DATA_W-1:0] hdata;

  int n_run = 0;
  int n_fail = 0;
  int next_idx = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rdata = pat(addr);

  sram_host_xfer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES),
    .BASE_ADDR(BASE), .RD_WAIT(RD_WAIT)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .xfer_len_i(len),
    .host_rtr_i(rtr), .sram_rdata_i(rdata), .sram_addr_o(addr),
    .sram_oe_o(oe), .host_data_o(hdata), .data_rdy_o(rdy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk);
    start = 1'b1;
    len   = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // one full host interlock for byte number next_idx
  task automatic host_byte(input int hold, input bit inject_start);
    int  up, dn;
    bit  saw_oe;
    logic [7:0] seen;
    logic [ADDR_W-1:0] exp_a;
    exp_a  = ADDR_W'(BASE + next_idx);
    up     = 0;
    saw_oe = 1'b0;
    @(negedge clk);
    rtr = 1'b1;
    while (!rdy && up < 50) begin
      @(negedge clk);
      up++;
      if (oe) saw_oe = 1'b1;
    end
    chk(up == UP_EDGES, "R3 rise latency", up, UP_EDGES);
    chk(saw_oe, "R8 oe during read", int'(saw_oe), 1);
    chk(hdata == pat(exp_a), "R4 byte value", int'(hdata), int'(pat(exp_a)));
    chk(addr == exp_a, "R6 address", int'(addr), int'(exp_a));
    seen = hdata;
    if (inject_start) begin
      start = 1'b1;
      len   = CNT_W'(1);
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(rdy, "R5 rdy held", int'(rdy), 1);
      chk(hdata == seen, "R4 bus stable", int'(hdata), int'(seen));
    end
    @(negedge clk);
    start = 1'b0;
    rtr = 1'b0;
    dn  = 0;
    while (rdy && dn < 50) begin
      @(negedge clk);
      dn++;
      if (rdy) chk(hdata == seen, "R4 bus stable", int'(hdata), int'(seen));
    end
    chk(dn == DN_EDGES, "R5 fall latency", dn, DN_EDGES);
    next_idx++;
  endtask

  task automatic run_xfer(input int n, input int hold, input int inject_at);
    pulse_start(n);
    chk(!done, "R2 done cleared by start", int'(done), 0);
    next_idx = 0;
    for (int i = 0; i < n; i++) begin
      host_byte(hold, i == inject_at);
      if (i < n - 1)
        chk(!done, "R7 done not early", int'(done), 0);
    end
    chk(done, "R7 done after last", int'(done), 1);
    chk(!oe, "R8 oe low when done", int'(oe), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rdy && !done && !oe, "R1 reset outputs", int'({rdy, done, oe}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(addr == ADDR_W'(BASE), "R1 reset address", int'(addr), BASE);

    for (int v = 0; v < 4; v++)
      run_xfer(int'(VEC[v][15:8]), int'(VEC[v][7:0]), -1);

    // R7: done persists while idle
    repeat (10) @(negedge clk);
    chk(done, "R7 done held", int'(done), 1);

    // R7: zero length
    @(negedge clk);
    start = 1'b1;
    len   = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done, "R7 zero length done", int'(done), 1);
    chk(!rdy && !oe, "R8 zero length quiet", int'({rdy, oe}), 0);

    // R2: start mid-transfer must be ignored
    run_xfer(4, 3, 1);

    // R2: done only clears on start, and a new run starts at base again
    run_xfer(2, 0, -1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule